// File: doc/BRIEF.md
# Dual-Bank Sweep Trace Processor

This block keeps two sweep traces of a spectrum display, called bank A and bank B, and processes them point by point. Digitized amplitude samples arrive one per cycle, each tagged with its horizontal point index. A 3-bit mode code decides which bank a sample updates and how. The modes are: loading A live, peak holding into B, freezing A while B runs live, showing B minus the frozen A, and splitting each point at a programmable cursor level. In split mode, samples above the cursor are peak held and samples at or below it are smoothed. The view modes freeze both banks.

A display scanner reads any point through a registered read port. It receives the raw contents of both banks and one processed amplitude chosen by the mode. An update marker reports the last point that was written, so the display can show where the live sweep is. A clear sequencer fills one chosen bank with zeros, one point per cycle. A two-register host port sets the mode and the cursor level.

Top module: `trace_store_top`

## Requirements
- R1: After reset the mode register is 0, the cursor register is 0x80, and marker, disp_valid, clr_busy and clr_done are all 0.
- R2: A host write to address 0 loads the mode from wdata[2:0], and reading address 0 returns the mode in bits [2:0] with bits [7:3] zero. Address 1 holds the 8-bit cursor and reads back unchanged.
- R3: Mode 7 (load A) writes each accepted sample into bank A at its index, and disp_out shows A.
- R4: Mode 3 (peak) replaces B[i] with the sample only when the sample is larger, and disp_out shows B. Bank A is untouched.
- R5: Mode 4 (hold A) writes no sample into A and writes each sample into B, and disp_out shows A.
- R6: Mode 5 (difference) keeps A frozen and writes each sample into B. disp_out is B minus A, clamped to 0 when A is larger.
- R7: Mode 6 (split) updates B. A sample strictly greater than the cursor gives max(B[i], sample). Any other sample gives B[i] + floor((sample - B[i]) / 4). disp_out shows B.
- R8: In modes 0, 1 and 2 no sample writes either bank. disp_out shows A in modes 0 and 2 and B in mode 1, and disp_a/disp_b always carry the raw contents.
- R9: disp_rd at a clock edge gives disp_valid and the data for disp_idx during the following cycle. A read and a sample write to the same point at the same edge return the value before that write.
- R10: marker takes the index of each accepted sample at the edge that writes it. A sample whose index is 500 or more is dropped and leaves the marker unchanged.
- R11: clr_start while idle raises clr_busy for 500 cycles, writing zero to points 0..499 of the bank chosen by clr_sel (0 = A, 1 = B). clr_done is then high for exactly one cycle, in the 501st cycle after the start edge.
- R12: While a clear is running, clr_start is ignored, and sample writes into the bank being cleared are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 1 | Host register select: 0 mode, 1 cursor |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for host_addr |
| smp_valid | input | 1 | Sample strobe |
| smp_idx | input | AW | Horizontal point index of the sample |
| smp_amp | input | DW | Sample amplitude, unsigned |
| disp_rd | input | 1 | Display read request |
| disp_idx | input | AW | Point index to read |
| disp_valid | output | 1 | Read data valid |
| disp_a | output | DW | Raw bank A value |
| disp_b | output | DW | Raw bank B value |
| disp_out | output | DW | Processed amplitude for the current mode |
| marker | output | AW | Index of the last written sample |
| clr_start | input | 1 | Start a bank clear |
| clr_sel | input | 1 | Bank to clear: 0 A, 1 B |
| clr_busy | output | 1 | Clear in progress |
| clr_done | output | 1 | One-cycle pulse when a clear finishes |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is a sweep write and a display read of the same point. The bench drives both at the same edge and expects the value from before the write, then reads the point again and expects the new value. The second pair is a clear and a sample write. The bench sends a sample into the bank being cleared at a point the clear has already passed. It also issues a second start in the middle of the clear. Afterwards it expects a zero at that point, the other bank unchanged, and clr_done at its regular cycle.

// File: rtl/trace_pkg.sv
package trace_pkg;
   typedef enum logic [2:0] {
      TM_VIEW_A  = 3'd0,
      TM_VIEW_B  = 3'd1,
      TM_VIEW_AB = 3'd2,
      TM_PEAK    = 3'd3,
      TM_HOLD_A  = 3'd4,
      TM_DIFF    = 3'd5,
      TM_SPLIT   = 3'd6,
      TM_LOAD_A  = 3'd7
   } trace_mode_e;

   localparam int NUM_BANKS = 2;
endpackage

// File: rtl/trace_host_regs.sv
module trace_host_regs
   import trace_pkg::*;
#(
   parameter int DW         = 8,
   parameter int CURSOR_RST = 128
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic          addr,
   input  logic [7:0]    wdata,
   output logic [7:0]    rdata,
   output trace_mode_e   mode,
   output logic [DW-1:0] cursor
);
   localparam logic [DW-1:0] CUR_INIT = DW'(CURSOR_RST);

   if (DW > 8) begin : g_bad_dw
      $error("trace_host_regs: cursor wider than the host data path");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode   <= TM_VIEW_A;
         cursor <= CUR_INIT;
      end else if (we) begin
         if (!addr) mode   <= trace_mode_e'(wdata[2:0]);
         else       cursor <= wdata[DW-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      if (!addr) rdata[2:0]   = mode;
      else       rdata[DW-1:0] = cursor;
   end
endmodule

// File: rtl/trace_clear_seq.sv
module trace_clear_seq #(
   parameter int NPTS = 500,
   parameter int AW   = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          sel,
   output logic          busy,
   output logic          done,
   output logic          bank,
   output logic [AW-1:0] addr
);
   localparam logic [AW-1:0] LAST = AW'(NPTS - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
         bank <= 1'b0;
         addr <= '0;
      end else begin
         done <= 1'b0;
         if (busy) begin
            if (addr == LAST) begin
               busy <= 1'b0;
               done <= 1'b1;
               addr <= '0;
            end else begin
               addr <= addr + 1'b1;
            end
         end else if (start) begin
            busy <= 1'b1;
            bank <= sel;
            addr <= '0;
         end
      end
   end
endmodule

// File: rtl/trace_point_alu.sv
module trace_point_alu
   import trace_pkg::*;
#(
   parameter int DW   = 8,
   parameter bit IS_A = 1'b0
) (
   input  trace_mode_e   mode,
   input  logic [DW-1:0] cursor,
   input  logic [DW-1:0] sample,
   input  logic [DW-1:0] stored,
   output logic          wr,
   output logic [DW-1:0] wdata
);
   if (IS_A) begin : g_bank_a
      always_comb begin
         wr    = (mode == TM_LOAD_A);
         wdata = sample;
      end
   end else begin : g_bank_b
      logic signed [DW+1:0] diff;
      logic signed [DW+1:0] step;
      logic signed [DW+1:0] avg;
      logic [DW-1:0]        peak;

      always_comb begin
         diff  = $signed({2'b00, sample}) - $signed({2'b00, stored});
         step  = diff >>> 2;
         avg   = $signed({2'b00, stored}) + step;
         peak  = (sample > stored) ? sample : stored;
         wr    = 1'b0;
         wdata = sample;
         case (mode)
            TM_PEAK: begin
               wr    = 1'b1;
               wdata = peak;
            end
            TM_HOLD_A, TM_DIFF: begin
               wr    = 1'b1;
               wdata = sample;
            end
            TM_SPLIT: begin
               wr    = 1'b1;
               wdata = (sample > cursor) ? peak : avg[DW-1:0];
            end
            default: wr = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/trace_bank.sv
module trace_bank #(
   parameter int NPTS = 500,
   parameter int AW   = 9,
   parameter int DW   = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] rmw_addr,
   output logic [DW-1:0] rmw_q,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_q
);
   logic [DW-1:0] mem [NPTS];

   always_comb begin
      rmw_q = '0;
      if (int'(rmw_addr) < NPTS) rmw_q = mem[rmw_addr];
   end

   always_ff @(posedge clk) begin
      if (we && int'(waddr) < NPTS) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_q <= '0;
      else if (rd_en) rd_q <= (int'(rd_addr) < NPTS) ? mem[rd_addr] : '0;
   end
endmodule

// File: rtl/trace_view.sv
module trace_view
   import trace_pkg::*;
#(
   parameter int DW = 8
) (
   input  trace_mode_e   mode,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic [DW-1:0] out
);
   always_comb begin
      case (mode)
         TM_VIEW_B, TM_PEAK, TM_SPLIT: out = b;
         TM_DIFF:                      out = (b > a) ? (b - a) : '0;
         default:                      out = a;
      endcase
   end
endmodule

// File: rtl/trace_store_top.sv
module trace_store_top
   import trace_pkg::*;
#(
   parameter int NPTS       = 500,
   parameter int DW         = 8,
   parameter int AW         = $clog2(NPTS),
   parameter int CURSOR_RST = 128
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_we,
   input  logic          host_addr,
   input  logic [7:0]    host_wdata,
   output logic [7:0]    host_rdata,
   input  logic          smp_valid,
   input  logic [AW-1:0] smp_idx,
   input  logic [DW-1:0] smp_amp,
   input  logic          disp_rd,
   input  logic [AW-1:0] disp_idx,
   output logic          disp_valid,
   output logic [DW-1:0] disp_a,
   output logic [DW-1:0] disp_b,
   output logic [DW-1:0] disp_out,
   output logic [AW-1:0] marker,
   input  logic          clr_start,
   input  logic          clr_sel,
   output logic          clr_busy,
   output logic          clr_done
);
   if (NPTS < 2 || (1 << AW) < NPTS) begin : g_bad_geom
      $error("trace_store_top: index width cannot cover NPTS");
   end
   if (DW < 2 || DW > 8) begin : g_bad_width
      $error("trace_store_top: DW must be 2..8");
   end

   trace_mode_e   mode_q;
   logic [DW-1:0] cursor_q;
   logic          clr_bank;
   logic [AW-1:0] clr_addr;
   logic          smp_ok;
   logic [DW-1:0] bank_rd [NUM_BANKS];

   assign smp_ok = smp_valid && (int'(smp_idx) < NPTS);

   trace_host_regs #(.DW(DW), .CURSOR_RST(CURSOR_RST)) i_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (host_we),
      .addr  (host_addr),
      .wdata (host_wdata),
      .rdata (host_rdata),
      .mode  (mode_q),
      .cursor(cursor_q)
   );

   trace_clear_seq #(.NPTS(NPTS), .AW(AW)) i_clr (
      .clk  (clk),
      .rst_n(rst_n),
      .start(clr_start),
      .sel  (clr_sel),
      .busy (clr_busy),
      .done (clr_done),
      .bank (clr_bank),
      .addr (clr_addr)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic          clr_hit;
      logic          alu_wr;
      logic [DW-1:0] alu_data;
      logic [DW-1:0] old_q;
      logic          we;
      logic [AW-1:0] waddr;
      logic [DW-1:0] wdata;

      assign clr_hit = clr_busy && (clr_bank == 1'(b));

      trace_point_alu #(.DW(DW), .IS_A(b == 0)) i_alu (
         .mode  (mode_q),
         .cursor(cursor_q),
         .sample(smp_amp),
         .stored(old_q),
         .wr    (alu_wr),
         .wdata (alu_data)
      );

      always_comb begin
         we    = clr_hit || (smp_ok && alu_wr);
         waddr = clr_hit ? clr_addr : smp_idx;
         wdata = clr_hit ? '0 : alu_data;
      end

      trace_bank #(.NPTS(NPTS), .AW(AW), .DW(DW)) i_mem (
         .clk     (clk),
         .rst_n   (rst_n),
         .we      (we),
         .waddr   (waddr),
         .wdata   (wdata),
         .rmw_addr(smp_idx),
         .rmw_q   (old_q),
         .rd_en   (disp_rd),
         .rd_addr (disp_idx),
         .rd_q    (bank_rd[b])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         marker     <= '0;
         disp_valid <= 1'b0;
      end else begin
         disp_valid <= disp_rd;
         if (smp_ok) marker <= smp_idx;
      end
   end

   assign disp_a = bank_rd[0];
   assign disp_b = bank_rd[1];

   trace_view #(.DW(DW)) i_view (
      .mode(mode_q),
      .a   (bank_rd[0]),
      .b   (bank_rd[1]),
      .out (disp_out)
   );
endmodule

// File: rtl/trace_store_chk.sv
module trace_store_chk
   import trace_pkg::*;
#(
   parameter int NPTS = 500,
   parameter int DW   = 8,
   parameter int AW   = 9
) (
   input logic          clk,
   input logic          rst_n,
   input logic          host_we,
   input logic          host_addr,
   input logic [7:0]    host_wdata,
   input trace_mode_e   mode_q,
   input logic          smp_valid,
   input logic [AW-1:0] smp_idx,
   input logic          disp_rd,
   input logic          disp_valid,
   input logic [DW-1:0] disp_b,
   input logic [DW-1:0] disp_out,
   input logic [AW-1:0] marker,
   input logic          clr_start,
   input logic          clr_busy,
   input logic          clr_done
);
   // R2
   mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && !host_addr) |=> (mode_q == trace_mode_e'($past(host_wdata[2:0]))));

   // R9
   rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      disp_rd |=> disp_valid);

   // R9
   rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !disp_rd |=> !disp_valid);

   // R6
   diff_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && mode_q == TM_DIFF) |-> (disp_out <= disp_b));

   // R10
   marker_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && int'(smp_idx) < NPTS) |=> (marker == $past(smp_idx)));

   // R10
   marker_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(smp_valid && int'(smp_idx) < NPTS) |=> $stable(marker));

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_done |-> (!clr_busy && $past(clr_busy)));

   // R11
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_done |=> !clr_done);

   // R12
   restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_busy && clr_start && !clr_done) |=> (clr_busy || clr_done));
endmodule

bind trace_store_top trace_store_chk #(.NPTS(NPTS), .DW(DW), .AW(AW)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .host_we   (host_we),
   .host_addr (host_addr),
   .host_wdata(host_wdata),
   .mode_q    (mode_q),
   .smp_valid (smp_valid),
   .smp_idx   (smp_idx),
   .disp_rd   (disp_rd),
   .disp_valid(disp_valid),
   .disp_b    (disp_b),
   .disp_out  (disp_out),
   .marker    (marker),
   .clr_start (clr_start),
   .clr_busy  (clr_busy),
   .clr_done  (clr_done)
);

// File: tb/test_trace_store_top.sv
module test_trace_store_top;
   localparam int NPTS = 500;
   localparam int DW   = 8;
   localparam int AW   = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_we = 1'b0;
   logic          host_addr = 1'b0;
   logic [7:0]    host_wdata = '0;
   logic [7:0]    host_rdata;
   logic          smp_valid = 1'b0;
   logic [AW-1:0] smp_idx = '0;
   logic [DW-1:0] smp_amp = '0;
   logic          disp_rd = 1'b0;
   logic [AW-1:0] disp_idx = '0;
   logic          disp_valid;
   logic [DW-1:0] disp_a, disp_b, disp_out;
   logic [AW-1:0] marker;
   logic          clr_start = 1'b0;
   logic          clr_sel = 1'b0;
   logic          clr_busy, clr_done;

   int checks = 0;
   int fails  = 0;
   int cur_mode = 0;
   int cursor = 128;
   int ma [NPTS];
   int mb [NPTS];

   always #4 clk = ~clk;

   trace_store_top i_trace_store_top (
      .clk(clk), .rst_n(rst_n),
      .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .smp_valid(smp_valid), .smp_idx(smp_idx), .smp_amp(smp_amp),
      .disp_rd(disp_rd), .disp_idx(disp_idx), .disp_valid(disp_valid),
      .disp_a(disp_a), .disp_b(disp_b), .disp_out(disp_out),
      .marker(marker), .clr_start(clr_start), .clr_sel(clr_sel),
      .clr_busy(clr_busy), .clr_done(clr_done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_out(input int m, input int a, input int b);
      case (m)
         1, 3, 6: return b;
         5:       return (b > a) ? b - a : 0;
         default: return a;
      endcase
   endfunction

   function automatic int split_val(input int s, input int o, input int cur);
      int d;
      if (s > cur) return (s > o) ? s : o;
      d = s - o;
      return o + (d >>> 2);
   endfunction

   task automatic model_sample(input int idx, input int amp);
      if (idx >= NPTS) return;
      case (cur_mode)
         7:    ma[idx] = amp;
         3:    if (amp > mb[idx]) mb[idx] = amp;
         4, 5: mb[idx] = amp;
         6:    mb[idx] = split_val(amp, mb[idx], cursor);
         default: ;
      endcase
   endtask

   task automatic host_write(input bit adr, input int val);
      @(negedge clk);
      host_we = 1'b1; host_addr = adr; host_wdata = 8'(val);
      @(negedge clk);
      host_we = 1'b0;
      if (!adr) cur_mode = val & 7;
      else      cursor = val & 255;
   endtask

   task automatic send_sample(input int idx, input int amp);
      @(negedge clk);
      smp_valid = 1'b1; smp_idx = AW'(idx); smp_amp = DW'(amp);
      @(negedge clk);
      smp_valid = 1'b0;
      model_sample(idx, amp);
   endtask

   task automatic read_check(input int idx, input string req);
      bit ok;
      @(negedge clk);
      disp_rd = 1'b1; disp_idx = AW'(idx);
      @(negedge clk);
      disp_rd = 1'b0;
      ok = disp_valid && (int'(disp_a) == ma[idx]) && (int'(disp_b) == mb[idx])
           && (int'(disp_out) == exp_out(cur_mode, ma[idx], mb[idx]));
      if (!ok)
         $display("FAIL %s point %0d a=%0d/%0d b=%0d/%0d out=%0d/%0d valid=%0d", req, idx,
                  disp_a, ma[idx], disp_b, mb[idx], disp_out,
                  exp_out(cur_mode, ma[idx], mb[idx]), disp_valid);
      checks++;
      if (!ok) fails++;
   endtask

   task automatic scan_all(input string req);
      for (int i = 0; i < NPTS; i++) read_check(i, req);
   endtask

   task automatic random_burst(input int n);
      for (int k = 0; k < n; k++) begin
         int idx = int'($urandom_range(NPTS - 1, 0));
         int amp = int'($urandom_range(255, 0));
         send_sample(idx, amp);
      end
   endtask

   // start a clear; optionally inject a sample into the cleared bank and a second start
   task automatic run_clear(input bit sel, input bit inject);
      int seen = 0;
      int busy_bad = 0;
      @(negedge clk);
      clr_start = 1'b1; clr_sel = sel;
      @(negedge clk);
      clr_start = 1'b0;
      for (int k = 1; k <= 501; k++) begin
         if (k > 1) @(negedge clk);
         smp_valid = 1'b0;
         clr_start = 1'b0;
         if (clr_done) seen = (seen == 0) ? k : seen;
         if (k <= 500 && !clr_busy) busy_bad++;
         if (inject && k == 100) begin
            smp_valid = 1'b1; smp_idx = '0; smp_amp = 8'd55;
         end
         if (inject && k == 200) begin
            clr_start = 1'b1; clr_sel = ~sel;
         end
      end
      @(negedge clk);
      // R11: done pulse at the 501st cycle only, busy throughout
      chk(seen == 501 && busy_bad == 0 && !clr_done && !clr_busy, "R11 clear timing", seen, 501);
      for (int i = 0; i < NPTS; i++) begin
         if (sel) mb[i] = 0;
         else     ma[i] = 0;
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      host_addr = 1'b0; #1;
      chk(host_rdata == 8'd0, "R1 mode reset", host_rdata, 0);
      host_addr = 1'b1; #1;
      chk(host_rdata == 8'h80, "R1 cursor reset", host_rdata, 128);
      chk(marker == '0 && !disp_valid && !clr_busy && !clr_done, "R1 status reset",
          {marker, disp_valid, clr_busy, clr_done}, 0);

      // R2 register readback
      host_write(1'b0, 8'hFD);
      host_addr = 1'b0; #1;
      chk(host_rdata == 8'd5, "R2 mode readback", host_rdata, 5);
      host_write(1'b1, 8'h5A);
      host_addr = 1'b1; #1;
      chk(host_rdata == 8'h5A, "R2 cursor readback", host_rdata, 90);

      // R11 clear both banks
      run_clear(1'b0, 1'b0);
      run_clear(1'b1, 1'b0);
      host_write(1'b0, 0);
      scan_all("R11 cleared");

      // R3 load A
      host_write(1'b0, 7);
      random_burst(900);
      scan_all("R3 load A");

      // R4 peak hold into B
      host_write(1'b0, 3);
      random_burst(900);
      scan_all("R4 peak hold");

      // R7 split at cursor
      host_write(1'b1, 8'h60);
      host_write(1'b0, 6);
      random_burst(1200);
      send_sample(7, 96);
      send_sample(7, 97);
      scan_all("R7 split");

      // R5 hold A, B live
      host_write(1'b0, 4);
      random_burst(600);
      scan_all("R5 hold A");

      // R6 difference
      host_write(1'b0, 5);
      random_burst(600);
      send_sample(11, 0);
      send_sample(12, 255);
      scan_all("R6 difference");

      // R8 view modes leave the banks alone
      for (int m = 0; m < 3; m++) begin
         host_write(1'b0, m);
         random_burst(50);
         scan_all("R8 view");
      end

      // R10 marker and out-of-range index
      host_write(1'b0, 7);
      send_sample(321, 17);
      @(negedge clk);
      chk(marker == AW'(321), "R10 marker", marker, 321);
      send_sample(505, 99);
      @(negedge clk);
      chk(marker == AW'(321), "R10 out of range ignored", marker, 321);
      read_check(321, "R10 point");

      // R9 read and write of the same point at the same edge
      @(negedge clk);
      smp_valid = 1'b1; smp_idx = AW'(10); smp_amp = DW'(ma[10] ^ 8'hA5);
      disp_rd = 1'b1; disp_idx = AW'(10);
      @(negedge clk);
      smp_valid = 1'b0; disp_rd = 1'b0;
      chk(disp_valid && int'(disp_a) == ma[10], "R9 read before write", disp_a, ma[10]);
      model_sample(10, ma[10] ^ 8'hA5);
      read_check(10, "R9 new value");

      // R12 sample into a bank being cleared is dropped, restart ignored
      host_write(1'b0, 5);
      run_clear(1'b1, 1'b1);
      read_check(0, "R12 dropped sample");
      scan_all("R12 other bank kept");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule